// File: doc/BRIEF.md
# Three-Lane Framed Deserializer with Embedded Control Bits

This block turns three serial bit streams back into one parallel word per frame. It runs on a bit-rate clock and takes a one-cycle frame strobe that marks the first bit slot of a frame. The strobe comes from the frame clock. Each frame produces a 21-bit data word. In balanced mode it also produces two 3-bit control groups, called group A and group B. A single-cycle strobe marks each new word.

A mode input selects one of two framings:

- **Balanced mode:** every lane carries nine slots per frame. Two of those slots are control bits placed at fixed positions among seven data bits.
- **Plain mode:** every lane carries seven data slots and no control bits.

The mode is sampled only at frame boundaries, so one frame is never decoded with a mix of layouts. After reset the block stays idle until it sees the first frame strobe. From then on it counts frames by itself, with no further strobes needed. A strobe that arrives partway through a frame drops the partial frame and starts a new one.

Top module: `lfd_deser`

## Requirements
- R1: While reset is held, and in the first cycle after it, `data_word`, `ctl_a` and `ctl_b` are zero and `word_valid` is low.
- R2: After reset, no word is produced and no output changes until `frame_sync` is seen high; lane activity before that is ignored.
- R3: When `bal_mode`=1 at a frame's first slot, lane k (k=0..2) carries slot 0..8 as: data bits 7k+0 to 7k+4 in slots 0..4, `ctl_a[k]` in slot 5, data bits 7k+5 and 7k+6 in slots 6 and 7, `ctl_b[k]` in slot 8. Slot 0 is the cycle in which `frame_sync` is high.
- R4: Once aligned, frames follow each other with no gap: 9 slots in balanced mode or 7 in plain mode. Each later frame starts in the cycle after the previous frame's last slot, whether or not `frame_sync` is repeated.
- R5: When `bal_mode`=0 at a frame's first slot, lane k carries data bits 7k+0 to 7k+6 in slots 0..6 in ascending order, and `ctl_a` and `ctl_b` are output as zero for that word.
- R6: `word_valid` is high for exactly one cycle, the cycle after a frame's last slot is sampled. All three output fields update together in that cycle and hold their values in every other cycle.
- R7: `bal_mode` is sampled only at a frame's first slot. Changes to it during slots 1 onward have no effect on that frame.
- R8: A `frame_sync` in any slot other than the expected first slot discards the partial frame: no word is produced for it, and the strobe's cycle becomes slot 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one lane bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sync | input | 1 | High in the cycle holding slot 0 of a frame |
| bal_mode | input | 1 | 1 = nine-slot balanced framing, 0 = seven-slot plain framing |
| lane_in | input | 3 | One serial bit per lane per cycle; bit k is lane k |
| data_word | output | 21 | Reassembled data word |
| ctl_a | output | 3 | First control bit of each lane; bit k from lane k |
| ctl_b | output | 3 | Second control bit of each lane; bit k from lane k |
| word_valid | output | 1 | One-cycle strobe when a new word appears |

## Verification
A frame's word and its strobe are due exactly one clock after the rising edge that samples the frame's last slot. No result is due in any other cycle.

The bench drives each slot on the falling edge. On the next falling edge it compares the strobe and all three output fields against a value computed independently for that cycle. That value is the expected new word in the one cycle where a word is due, and the previously held word in every other cycle. Because of this, a word that arrives a cycle late, an extra strobe, or an output that changes between words all show up in the same cycle they happen.

// File: rtl/lfd_pkg.sv
// Shared constants and types for the three-lane framed deserializer.
// Assumes at most 16 slots per frame so a 4-bit slot index suffices.
package lfd_pkg;
    localparam int LANES      = 3;
    localparam int LANE_DATA  = 7;
    localparam int SLOTS_BAL  = 9;
    localparam int SLOTS_RAW  = 7;
    localparam int WORD_W     = LANES * LANE_DATA;
    localparam int SLOT_W     = $clog2(SLOTS_BAL + 1);
    // Balanced-mode slot positions of the two control bits.
    localparam int SLOT_CTL_A = 5;
    localparam int SLOT_CTL_B = 8;

    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/lfd_slot_ctr.sv
// Frame alignment and slot counter.
// Assumes frame_sync marks slot 0 in the same cycle it is high. Produces the
// slot index of the bit presented this cycle, the mode in force for the
// current frame (sampled only at boundaries) and a last-slot flag.
module lfd_slot_ctr
    import lfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_sync,
    input  logic  bal_mode,
    output slot_t cur_slot,
    output logic  cur_mode,
    output logic  active,
    output logic  frame_done
);
    logic  aligned_q;
    logic  mode_q;
    slot_t nxt_q;
    logic  boundary;
    slot_t last_slot;

    // Decode the current slot, the frame mode and the end of frame.
    always_comb begin
        boundary   = frame_sync | (aligned_q & (nxt_q == '0));
        cur_mode   = boundary ? bal_mode : mode_q;
        cur_slot   = frame_sync ? '0 : nxt_q;
        active     = frame_sync | aligned_q;
        last_slot  = cur_mode ? slot_t'(SLOTS_BAL - 1) : slot_t'(SLOTS_RAW - 1);
        frame_done = active & (cur_slot == last_slot);
    end

    // Track alignment, latch the mode at boundaries, advance the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aligned_q <= 1'b0;
            mode_q    <= 1'b0;
            nxt_q     <= '0;
        end else begin
            if (frame_sync) aligned_q <= 1'b1;
            if (boundary)   mode_q    <= bal_mode;
            if (!active || frame_done) nxt_q <= '0;
            else                       nxt_q <= cur_slot + 1'b1;
        end
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        nxt_q <= slot_t'(SLOTS_BAL - 1)); // R4
    AST_RAW_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && !mode_q) |-> (nxt_q <= slot_t'(SLOTS_RAW - 1))); // R5
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (nxt_q == slot_t'(1))); // R8
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (aligned_q && nxt_q != '0 && !frame_sync) |=> $stable(mode_q)); // R7
endmodule

// File: rtl/lfd_lane_cap.sv
// One lane's slot capture buffer.
// Stores each bit at its slot index while aligned, and exposes the whole
// frame with the bit of the current cycle already substituted, so the
// output stage can take a frame in the same cycle as its last slot.
module lfd_lane_cap
    import lfd_pkg::*;
#(
    parameter int SLOTS = SLOTS_BAL
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane_bit,
    input  slot_t            cur_slot,
    input  logic             active,
    output logic [SLOTS-1:0] frame_bits
);
    logic [SLOTS-1:0] buf_q;

    // Write the incoming bit into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (active && cur_slot == slot_t'(s)) buf_q[s] <= lane_bit;
            end
        end
    end

    // Bypass the live bit into its slot position.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign frame_bits[s] = (active && cur_slot == slot_t'(s)) ? lane_bit : buf_q[s];
    end
endmodule

// File: rtl/lfd_out_reg.sv
// Output mapping and registers.
// Maps each lane's slot frame onto the data word and control bits in the
// layout of the frame's mode, and loads all outputs together on frame_done.
module lfd_out_reg
    import lfd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_done,
    input  logic                           cur_mode,
    input  logic [LANES-1:0][SLOTS_BAL-1:0] lane_frames,
    output logic [WORD_W-1:0]              data_word,
    output logic [LANES-1:0]               ctl_a,
    output logic [LANES-1:0]               ctl_b,
    output logic                           word_valid
);
    logic [WORD_W-1:0] map_word;
    logic [LANES-1:0]  map_a;
    logic [LANES-1:0]  map_b;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Pick this lane's data and control bits for the active layout.
        always_comb begin
            if (cur_mode) begin
                for (int i = 0; i < SLOT_CTL_A; i++)
                    map_word[k*LANE_DATA + i] = lane_frames[k][i];
                for (int i = SLOT_CTL_A; i < LANE_DATA; i++)
                    map_word[k*LANE_DATA + i] = lane_frames[k][i+1];
                map_a[k] = lane_frames[k][SLOT_CTL_A];
                map_b[k] = lane_frames[k][SLOT_CTL_B];
            end else begin
                for (int i = 0; i < LANE_DATA; i++)
                    map_word[k*LANE_DATA + i] = lane_frames[k][i];
                map_a[k] = 1'b0;
                map_b[k] = 1'b0;
            end
        end
    end

    // Load the mapped frame and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_word  <= '0;
            ctl_a      <= '0;
            ctl_b      <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= frame_done;
            if (frame_done) begin
                data_word <= map_word;
                ctl_a     <= map_a;
                ctl_b     <= map_b;
            end
        end
    end

    AST_RAW_CTL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !cur_mode) |=> (ctl_a == '0 && ctl_b == '0)); // R5
endmodule

// File: rtl/lfd_deser.sv
// Three-lane framed deserializer, top level.
// Assumes clk runs at the lane bit rate and frame_sync, when present, is
// high for the cycle carrying slot 0. Wires the slot counter, one capture
// buffer per lane and the output stage.
module lfd_deser
    import lfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              bal_mode,
    input  logic [LANES-1:0]  lane_in,
    output logic [WORD_W-1:0] data_word,
    output logic [LANES-1:0]  ctl_a,
    output logic [LANES-1:0]  ctl_b,
    output logic              word_valid
);
    slot_t cur_slot;
    logic  cur_mode;
    logic  active;
    logic  frame_done;
    logic [LANES-1:0][SLOTS_BAL-1:0] lane_frames;

    lfd_slot_ctr u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .bal_mode   (bal_mode),
        .cur_slot   (cur_slot),
        .cur_mode   (cur_mode),
        .active     (active),
        .frame_done (frame_done)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_cap
        lfd_lane_cap #(.SLOTS(SLOTS_BAL)) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_bit   (lane_in[k]),
            .cur_slot   (cur_slot),
            .active     (active),
            .frame_bits (lane_frames[k])
        );
    end

    lfd_out_reg u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .cur_mode    (cur_mode),
        .lane_frames (lane_frames),
        .data_word   (data_word),
        .ctl_a       (ctl_a),
        .ctl_b       (ctl_b),
        .word_valid  (word_valid)
    );

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R6
    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(data_word) && $stable(ctl_a) && $stable(ctl_b))); // R6
endmodule

// File: tb/lfd_deser_tb.sv
// Self-checking bench: vector table of frames, then directed tests.
module lfd_deser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        bal_mode = 1'b0;
    logic [2:0]  lane_in = 3'b000;
    logic [20:0] data_word;
    logic [2:0]  ctl_a, ctl_b;
    logic        word_valid;

    int checks = 0;
    int errors = 0;
    logic        exp_v = 1'b0;
    logic [20:0] hold_d = '0;
    logic [2:0]  hold_a = '0, hold_b = '0;
    string       exp_req = "R6";

    always #5 clk = ~clk;

    lfd_deser u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .bal_mode(bal_mode),
        .lane_in(lane_in), .data_word(data_word), .ctl_a(ctl_a), .ctl_b(ctl_b),
        .word_valid(word_valid)
    );

    // {mode, ctl_a, ctl_b, data}
    localparam logic [27:0] VEC [8] = '{
        {1'b1, 3'b101, 3'b010, 21'h1F0F0F},
        {1'b1, 3'b000, 3'b111, 21'h000001},
        {1'b0, 3'b111, 3'b111, 21'h155555},
        {1'b1, 3'b110, 3'b001, 21'h0AAAAA},
        {1'b0, 3'b000, 3'b000, 21'h1FFFFF},
        {1'b0, 3'b010, 3'b101, 21'h123456},
        {1'b1, 3'b011, 3'b100, 21'h100000},
        {1'b1, 3'b111, 3'b111, 21'h1FFFFF}
    };

    // Serial bit of lane k at slot s, built from the requirement tables.
    function automatic logic ser_bit(input logic m, input int k, input int s,
                                     input logic [20:0] d, input logic [2:0] a,
                                     input logic [2:0] b);
        if (!m) return d[7*k + s];
        if (s < 5)  return d[7*k + s];
        if (s == 5) return a[k];
        if (s == 8) return b[k];
        return d[7*k + s - 1];
    endfunction

    // One cycle: check outputs against the due value, then drive new inputs.
    task automatic tick(input logic s, input logic m, input logic [2:0] ln);
        @(negedge clk);
        checks++;
        if (word_valid !== exp_v) begin
            errors++;
            $display("FAIL R6 word_valid got %b exp %b", word_valid, exp_v);
        end
        checks++;
        if ({data_word, ctl_a, ctl_b} !== {hold_d, hold_a, hold_b}) begin
            errors++;
            $display("FAIL %s word got %h/%b/%b exp %h/%b/%b", exp_req,
                     data_word, ctl_a, ctl_b, hold_d, hold_a, hold_b);
        end
        frame_sync = s;
        bal_mode   = m;
        lane_in    = ln;
        exp_v      = 1'b0;
    endtask

    // Drive one full frame; glitch toggles the mode on slots after the first.
    task automatic send_frame(input logic m, input logic [20:0] d, input logic [2:0] a,
                              input logic [2:0] b, input logic sync, input logic glitch,
                              input string req);
        int n;
        n = m ? 9 : 7;
        for (int s = 0; s < n; s++) begin
            logic [2:0] ln;
            for (int k = 0; k < 3; k++) ln[k] = ser_bit(m, k, s, d, a, b);
            tick(sync && s == 0, (glitch && s != 0) ? !m : m, ln);
        end
        exp_v   = 1'b1;
        hold_d  = d;
        hold_a  = m ? a : 3'b000;
        hold_b  = m ? b : 3'b000;
        exp_req = req;
    endtask

    // Synchronous reset with a check of the reset state.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_sync = 1'b0; lane_in = 3'b000;
        repeat (2) @(negedge clk);
        checks++;
        if ({data_word, ctl_a, ctl_b, word_valid} !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs got %h/%b/%b/%b exp 0",
                     data_word, ctl_a, ctl_b, word_valid);
        end
        rst_n = 1'b1;
        exp_v = 1'b0; hold_d = '0; hold_a = '0; hold_b = '0; exp_req = "R1";
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();                                   // R1
        // R2: lanes toggle without any frame strobe; nothing may appear.
        exp_req = "R2";
        for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, 3'(i * 5 + 3));
        // Vector table: every frame starts with a strobe (R3 / R5).
        for (int v = 0; v < 8; v++) begin
            send_frame(VEC[v][27], VEC[v][20:0], VEC[v][26:24], VEC[v][23:21],
                       1'b1, 1'b0, VEC[v][27] ? "R3" : "R5");
        end
        // R4: frames follow with no strobe, including a mode change at the wrap.
        send_frame(1'b1, 21'h0F1E2D, 3'b100, 3'b011, 1'b0, 1'b0, "R4");
        send_frame(1'b0, 21'h17A5C3, 3'b111, 3'b111, 1'b0, 1'b0, "R4");
        send_frame(1'b1, 21'h0C3A5F, 3'b001, 3'b110, 1'b0, 1'b0, "R4");
        // R7: mode toggles mid-frame; the frame keeps its first-slot layout.
        send_frame(1'b1, 21'h1B6DB6, 3'b010, 3'b101, 1'b1, 1'b1, "R7");
        send_frame(1'b0, 21'h049249, 3'b111, 3'b111, 1'b1, 1'b1, "R7");
        // R8: partial frame cut short by a misplaced strobe.
        for (int s = 0; s < 4; s++) tick(s == 0, 1'b1, 3'b111);
        exp_req = "R8";
        send_frame(1'b1, 21'h0055AA, 3'b011, 3'b001, 1'b1, 1'b0, "R8");
        // Reset in operation, then R2 alignment again.
        tick(1'b0, 1'b0, 3'b000);
        do_reset();                                   // R1
        exp_req = "R2";
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b0, 3'b101);
        send_frame(1'b0, 21'h1C71C7, 3'b000, 3'b000, 1'b1, 1'b0, "R5");
        tick(1'b0, 1'b0, 3'b000);
        finish_run();
    end
endmodule